// File: doc/BRIEF.md
# Misaligned Data Access Splitter

This block sits between a load/store unit and a 32-bit data bus. It takes one memory request at a time: a byte address, an element size (byte, halfword or word), a write flag, a signed flag for loads, and write data. Any request that the bus cannot serve as one transfer is broken into a series of aligned transfers, issued one after another. For loads, the returned bytes are gathered in address order into a right-aligned result and then extended. For stores, each write byte is steered onto its lane and the byte strobes are set. When the series ends, one completion is reported, and an error flag is set if any transfer failed.

A build-time parameter selects the splitting policy. In the wide policy (`NARROW=0`), an access that crosses a word boundary becomes two word-aligned transfers with partial byte strobes. In the narrow policy (`NARROW=1`), every unaligned access is broken into naturally aligned byte and halfword pieces, which takes up to three transfers.

All three streams use valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. A bus transfer is taken on a cycle where `bus_req_valid` and `bus_req_ready` are both high. The completion is consumed on a cycle where `rsp_valid` and `rsp_ready` are both high. While a producer is stalled by its consumer, it holds its valid signal and its payload steady. Only one bus transfer is ever outstanding. The bus returns exactly one `bus_rsp_valid` pulse per accepted transfer, no earlier than the cycle after acceptance, and has no ready signal.

Top module: `misalign_splitter`

## Requirements
- R1: A single transfer is issued in these cases: a naturally aligned access in either policy, and any access in the wide policy whose bytes all lie in one word. That transfer goes to the word-aligned address (`bus_addr[1:0]=0`), and `bus_be` bit j is set exactly for the byte lanes j that the access covers (lane j is byte address bits [1:0] = j).
- R2: In the wide policy, an access that crosses a word boundary makes two transfers. The first goes to the word holding the start address, with lanes from the start offset up to 3. The second goes to the next word, with lanes 0 upward for the remaining bytes.
- R3: In the narrow policy, unaligned accesses are split into pieces issued in ascending address order. A word at offset 1 or 3 becomes byte, aligned halfword, byte. A word at offset 2 becomes two halfwords. A halfword at offset 1 or 3 becomes two bytes. Each piece's strobes cover only its own one or two naturally aligned lanes.
- R4: On every write transfer, byte b of `req_wdata` (bits 8b+7..8b) appears on lane (start offset + b) mod 4 of `bus_wdata` wherever that lane's strobe is set. `bus_we` equals the request's write flag.
- R5: Sizes are encoded on `req_size` as 0=byte, 1=halfword, 2=word. A load returns memory byte (address+b) in result byte b. Above the element, the result is filled with copies of the element's top bit when `req_signed`=1, and with zeros when `req_signed`=0. A store returns `rsp_rdata`=0.
- R6: If a transfer returns `bus_rsp_err`=1, no further transfer of that access is issued. The completion follows on the next cycle with `rsp_err`=1 and `rsp_rdata`=0.
- R7: `req_ready` is high only when no access is in progress. After reset, and after each completion is consumed, it is high and no bus transfer or completion is pending.
- R8: A stalled `bus_req_valid` or `rsp_valid` stays high with an unchanged payload until it is accepted. After a transfer is accepted, no new transfer is issued until its response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_write | input | 1 | 1 for a store |
| req_signed | input | 1 | Sign-extend the load result |
| req_wdata | input | 32 | Store data, right-aligned |
| rsp_valid | output | 1 | Completion pending |
| rsp_ready | input | 1 | Completion consumed |
| rsp_rdata | output | 32 | Extended load result, 0 for stores and errors |
| rsp_err | output | 1 | Some transfer of the access failed |
| bus_req_valid | output | 1 | Bus transfer offered |
| bus_req_ready | input | 1 | Bus takes the transfer |
| bus_addr | output | ADDR_W | Word-aligned transfer address |
| bus_we | output | 1 | Transfer is a write |
| bus_be | output | 4 | Byte lane strobes |
| bus_wdata | output | 32 | Lane-steered write data |
| bus_rsp_valid | input | 1 | Response for the outstanding transfer |
| bus_rsp_rdata | input | 32 | Read data, by lane |
| bus_rsp_err | input | 1 | Transfer failed |

## Verification
A wrong piece index or a wrong plan shows on the very transfer it affects. The strobes or the word address differ from the expected piece, and this is visible on the same cycle `bus_req_valid` rises. A corrupted merge register stays hidden on the bus and only shows in `rsp_rdata` at the completion, one cycle after the last response. For this reason every load pattern is compared byte by byte against a memory model. A stuck state shows at once as an extra transfer after an error, as `req_ready` rising too early, or as a completion that drops while stalled.

// File: rtl/splitter_pkg.sv
package splitter_pkg;
  localparam int LANES  = 4;
  localparam int DATA_W = 8 * LANES;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } spl_state_e;

  // One bus piece: first data byte it carries, how many, and whether it ends the access.
  typedef struct packed {
    logic [1:0] boff;
    logic [2:0] nbytes;
    logic       last;
  } piece_t;
endpackage

// File: rtl/split_piece_planner.sv
module split_piece_planner
  import splitter_pkg::*;
#(
  parameter bit NARROW = 1'b0
) (
  input  logic [1:0] off,
  input  logic [1:0] size,
  input  logic [1:0] idx,
  output piece_t     piece
);
  logic [2:0] full_bytes;

  always_comb begin
    case (size)
      2'd0:    full_bytes = 3'd1;
      2'd1:    full_bytes = 3'd2;
      default: full_bytes = 3'd4;
    endcase
  end

  if (NARROW) begin : g_narrow
    always_comb begin
      piece.boff   = 2'd0;
      piece.nbytes = full_bytes;
      piece.last   = 1'b1;
      if (size == 2'd1 && off[0]) begin
        piece.nbytes = 3'd1;
        piece.boff   = (idx == 2'd0) ? 2'd0 : 2'd1;
        piece.last   = (idx != 2'd0);
      end else if (size[1] && off == 2'd2) begin
        piece.nbytes = 3'd2;
        piece.boff   = (idx == 2'd0) ? 2'd0 : 2'd2;
        piece.last   = (idx != 2'd0);
      end else if (size[1] && off[0]) begin
        case (idx)
          2'd0: begin piece.boff = 2'd0; piece.nbytes = 3'd1; piece.last = 1'b0; end
          2'd1: begin piece.boff = 2'd1; piece.nbytes = 3'd2; piece.last = 1'b0; end
          default: begin piece.boff = 2'd3; piece.nbytes = 3'd1; piece.last = 1'b1; end
        endcase
      end
    end
  end else begin : g_wide
    logic [3:0] span;
    logic [2:0] head;
    assign span = {2'b00, off} + {1'b0, full_bytes};
    assign head = 3'd4 - {1'b0, off};
    always_comb begin
      piece.boff   = 2'd0;
      piece.nbytes = full_bytes;
      piece.last   = 1'b1;
      if (span > 4'd4) begin
        if (idx == 2'd0) begin
          piece.nbytes = head;
          piece.last   = 1'b0;
        end else begin
          piece.boff   = head[1:0];
          piece.nbytes = full_bytes - head;
        end
      end
    end
  end
endmodule

// File: rtl/split_lane_steer.sv
module split_lane_steer
  import splitter_pkg::*;
(
  input  logic [1:0]        off,
  input  piece_t            piece,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic [DATA_W-1:0] rdata_in,
  output logic [LANES-1:0]  lane_be,
  output logic [DATA_W-1:0] lane_wdata,
  output logic [LANES-1:0]  data_mask,
  output logic [DATA_W-1:0] rdata_rot
);
  logic [2:0] piece_end;
  assign piece_end = {1'b0, piece.boff} + piece.nbytes;

  for (genvar b = 0; b < LANES; b++) begin : g_byte
    logic [1:0] src_lane;
    assign data_mask[b] = (3'(b) >= {1'b0, piece.boff}) && (3'(b) < piece_end);
    assign src_lane     = 2'(b) + off;
    assign rdata_rot[8*b +: 8] = rdata_in[{src_lane, 3'b000} +: 8];
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [1:0] src_byte;
    assign src_byte = 2'(j) - off;
    assign lane_be[j] = data_mask[src_byte];
    assign lane_wdata[8*j +: 8] = wdata_in[{src_byte, 3'b000} +: 8];
  end
endmodule

// File: rtl/misalign_splitter.sv
module misalign_splitter
  import splitter_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter bit NARROW = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic              req_signed,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_we,
  output logic [3:0]        bus_be,
  output logic [31:0]       bus_wdata,
  input  logic              bus_rsp_valid,
  input  logic [31:0]       bus_rsp_rdata,
  input  logic              bus_rsp_err
);
  spl_state_e        state;
  logic [ADDR_W-1:0] a_addr;
  logic [1:0]        a_size;
  logic              a_we;
  logic              a_sgn;
  logic [DATA_W-1:0] a_wdata;
  logic [1:0]        idx;
  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] acc_next;
  logic              err_q;

  piece_t            piece;
  logic [LANES-1:0]  data_mask;
  logic [DATA_W-1:0] rdata_rot;
  logic [ADDR_W-1:0] piece_addr;
  logic [DATA_W-1:0] ext;

  split_piece_planner #(.NARROW(NARROW)) u_plan (
    .off   (a_addr[1:0]),
    .size  (a_size),
    .idx   (idx),
    .piece (piece)
  );

  split_lane_steer u_steer (
    .off        (a_addr[1:0]),
    .piece      (piece),
    .wdata_in   (a_wdata),
    .rdata_in   (bus_rsp_rdata),
    .lane_be    (bus_be),
    .lane_wdata (bus_wdata),
    .data_mask  (data_mask),
    .rdata_rot  (rdata_rot)
  );

  assign piece_addr    = a_addr + ADDR_W'(piece.boff);
  assign bus_addr      = {piece_addr[ADDR_W-1:2], 2'b00};
  assign bus_we        = a_we;
  assign req_ready     = (state == ST_IDLE);
  assign bus_req_valid = (state == ST_ISSUE);
  assign rsp_valid     = (state == ST_DONE);
  assign rsp_err       = err_q;

  for (genvar b = 0; b < LANES; b++) begin : g_merge
    assign acc_next[8*b +: 8] = data_mask[b] ? rdata_rot[8*b +: 8] : acc[8*b +: 8];
  end

  always_comb begin
    case (a_size)
      2'd0:    ext = {{24{a_sgn & acc[7]}}, acc[7:0]};
      2'd1:    ext = {{16{a_sgn & acc[15]}}, acc[15:0]};
      default: ext = acc;
    endcase
  end

  assign rsp_rdata = (err_q || a_we) ? '0 : ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      a_addr  <= '0;
      a_size  <= '0;
      a_we    <= 1'b0;
      a_sgn   <= 1'b0;
      a_wdata <= '0;
      idx     <= '0;
      acc     <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            a_addr  <= req_addr;
            a_size  <= req_size;
            a_we    <= req_write;
            a_sgn   <= req_signed;
            a_wdata <= req_wdata;
            idx     <= '0;
            acc     <= '0;
            err_q   <= 1'b0;
            state   <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (bus_req_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (bus_rsp_valid) begin
            acc <= acc_next;
            if (bus_rsp_err) begin
              err_q <= 1'b1;
              state <= ST_DONE;
            end else if (piece.last) begin
              state <= ST_DONE;
            end else begin
              idx   <= idx + 2'd1;
              state <= ST_ISSUE;
            end
          end
        end
        default: begin
          if (rsp_ready) state <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/splitter_checker.sv
module splitter_checker #(
  parameter int ADDR_W = 32,
  parameter bit NARROW = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_rdata,
  input logic              rsp_err,
  input logic              bus_req_valid,
  input logic              bus_req_ready,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [3:0]        bus_be,
  input logic [31:0]       bus_wdata,
  input logic              bus_rsp_valid,
  input logic              bus_rsp_err
);
  logic be_narrow_ok;
  assign be_narrow_ok = (bus_be == 4'b0001) || (bus_be == 4'b0010) || (bus_be == 4'b0100) ||
                        (bus_be == 4'b1000) || (bus_be == 4'b0011) || (bus_be == 4'b1100) ||
                        (bus_be == 4'b1111);

  AST_BE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> (bus_be != 4'b0000 && bus_addr[1:0] == 2'b00)); // R1

  AST_NARROW_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && NARROW) |-> be_narrow_ok); // R3

  AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rsp_valid && bus_rsp_err) |=> (!bus_req_valid && rsp_valid && rsp_err && rsp_rdata == 32'd0)); // R6

  AST_IDLE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!bus_req_valid && !rsp_valid)); // R7

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && !bus_req_ready) |=>
      (bus_req_valid && $stable(bus_addr) && $stable(bus_be) && $stable(bus_we) && $stable(bus_wdata))); // R8

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && bus_req_ready) |=> !bus_req_valid); // R8

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err))); // R8
endmodule

bind misalign_splitter splitter_checker #(.ADDR_W(ADDR_W), .NARROW(NARROW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_rdata     (rsp_rdata),
  .rsp_err       (rsp_err),
  .bus_req_valid (bus_req_valid),
  .bus_req_ready (bus_req_ready),
  .bus_addr      (bus_addr),
  .bus_we        (bus_we),
  .bus_be        (bus_be),
  .bus_wdata     (bus_wdata),
  .bus_rsp_valid (bus_rsp_valid),
  .bus_rsp_err   (bus_rsp_err)
);

// File: tb/misalign_splitter_tb.sv
module misalign_splitter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic        req_valid [2];
  logic        req_ready [2];
  logic [31:0] req_addr [2];
  logic [1:0]  req_size [2];
  logic        req_write [2];
  logic        req_signed [2];
  logic [31:0] req_wdata [2];
  logic        rsp_valid [2];
  logic        rsp_ready [2];
  logic [31:0] rsp_rdata [2];
  logic        rsp_err [2];
  logic        bus_req_valid [2];
  logic        bus_req_ready [2];
  logic [31:0] bus_addr [2];
  logic        bus_we [2];
  logic [3:0]  bus_be [2];
  logic [31:0] bus_wdata [2];
  logic        bus_rsp_valid [2];
  logic [31:0] bus_rsp_rdata [2];
  logic        bus_rsp_err [2];

  misalign_splitter #(.ADDR_W(32), .NARROW(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid[0]), .req_ready(req_ready[0]), .req_addr(req_addr[0]),
    .req_size(req_size[0]), .req_write(req_write[0]), .req_signed(req_signed[0]),
    .req_wdata(req_wdata[0]), .rsp_valid(rsp_valid[0]), .rsp_ready(rsp_ready[0]),
    .rsp_rdata(rsp_rdata[0]), .rsp_err(rsp_err[0]),
    .bus_req_valid(bus_req_valid[0]), .bus_req_ready(bus_req_ready[0]),
    .bus_addr(bus_addr[0]), .bus_we(bus_we[0]), .bus_be(bus_be[0]), .bus_wdata(bus_wdata[0]),
    .bus_rsp_valid(bus_rsp_valid[0]), .bus_rsp_rdata(bus_rsp_rdata[0]), .bus_rsp_err(bus_rsp_err[0])
  );

  misalign_splitter #(.ADDR_W(32), .NARROW(1'b1)) u_dut_narrow (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid[1]), .req_ready(req_ready[1]), .req_addr(req_addr[1]),
    .req_size(req_size[1]), .req_write(req_write[1]), .req_signed(req_signed[1]),
    .req_wdata(req_wdata[1]), .rsp_valid(rsp_valid[1]), .rsp_ready(rsp_ready[1]),
    .rsp_rdata(rsp_rdata[1]), .rsp_err(rsp_err[1]),
    .bus_req_valid(bus_req_valid[1]), .bus_req_ready(bus_req_ready[1]),
    .bus_addr(bus_addr[1]), .bus_we(bus_we[1]), .bus_be(bus_be[1]), .bus_wdata(bus_wdata[1]),
    .bus_rsp_valid(bus_rsp_valid[1]), .bus_rsp_rdata(bus_rsp_rdata[1]), .bus_rsp_err(bus_rsp_err[1])
  );

  function automatic logic [7:0] mem_byte(input int unsigned a);
    int unsigned v;
    v = (a * 29) + (a >> 8) + 147;
    return 8'(v & 255);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // One access through the selected instance; expected pieces come from a behavioural model.
  task automatic run_op(input int m, input int unsigned addr, input int size, input bit we,
                        input bit sg, input logic [31:0] wd, input int errp);
    int unsigned pstart[$];
    int unsigned plen[$];
    int unsigned cur;
    int unsigned fin;
    int nb;
    bit err_hit;
    string tg;
    logic [31:0] ev;
    logic [31:0] held_addr;
    logic [3:0]  held_be;
    logic [31:0] held_rd;
    bit          held_err;

    nb  = 1 << size;
    cur = addr;
    fin = addr + nb;
    while (cur < fin) begin
      int unsigned len;
      if (m == 0) begin
        int unsigned nxt;
        nxt = (cur & ~32'd3) + 4;
        len = ((nxt < fin) ? nxt : fin) - cur;
      end else if ((addr % nb) == 0) begin
        len = nb;
      end else begin
        len = 1;
        for (int s = 4; s >= 2; s = s / 2) begin
          if (len == 1 && (cur % s) == 0 && cur + s <= fin) len = s;
        end
      end
      pstart.push_back(cur);
      plen.push_back(len);
      cur = cur + len;
    end

    while (!req_ready[m]) @(negedge clk);
    req_addr[m]   = addr;
    req_size[m]   = 2'(size);
    req_write[m]  = we;
    req_signed[m] = sg;
    req_wdata[m]  = wd;
    req_valid[m]  = 1'b1;
    @(negedge clk);
    req_valid[m]  = 1'b0;
    chk(req_ready[m] == 1'b0, "R7 busy", {31'd0, req_ready[m]}, 32'd0);

    err_hit = 1'b0;
    for (int k = 0; k < pstart.size(); k++) begin
      int unsigned word;
      logic [3:0]  ebe;
      int          wait_n;
      wait_n = 0;
      while (!bus_req_valid[m] && wait_n < 50) begin
        @(negedge clk);
        wait_n++;
      end
      tg = (m == 1) ? "R3" : ((pstart.size() == 1) ? "R1" : "R2");
      chk(bus_req_valid[m] == 1'b1, tg, {31'd0, bus_req_valid[m]}, 32'd1);
      if (!bus_req_valid[m]) return;
      word = pstart[k] & ~32'd3;
      ebe  = 4'd0;
      for (int i = 0; i < int'(plen[k]); i++) ebe[(pstart[k] + i) % 4] = 1'b1;
      chk(bus_addr[m] == word, tg, bus_addr[m], word);
      chk(bus_be[m] == ebe, tg, {28'd0, bus_be[m]}, {28'd0, ebe});
      chk(bus_we[m] == we, "R4", {31'd0, bus_we[m]}, {31'd0, we});
      if (we) begin
        for (int j = 0; j < 4; j++) begin
          if (ebe[j]) begin
            int b;
            b = int'(word) + j - int'(addr);
            chk(bus_wdata[m][8*j +: 8] == wd[8*b +: 8], "R4",
                {24'd0, bus_wdata[m][8*j +: 8]}, {24'd0, wd[8*b +: 8]});
          end
        end
      end
      if (k == 0) begin
        held_addr = bus_addr[m];
        held_be   = bus_be[m];
        @(negedge clk);
        chk(bus_req_valid[m] && bus_addr[m] == held_addr && bus_be[m] == held_be, "R8 hold",
            bus_addr[m], held_addr);
      end
      bus_req_ready[m] = 1'b1;
      @(negedge clk);
      bus_req_ready[m] = 1'b0;
      chk(bus_req_valid[m] == 1'b0, "R8 outstanding", {31'd0, bus_req_valid[m]}, 32'd0);
      for (int j = 0; j < 4; j++) bus_rsp_rdata[m][8*j +: 8] = mem_byte(word + 32'(j));
      bus_rsp_err[m]   = (k == errp);
      bus_rsp_valid[m] = 1'b1;
      @(negedge clk);
      bus_rsp_valid[m] = 1'b0;
      bus_rsp_err[m]   = 1'b0;
      if (k == errp) begin
        err_hit = 1'b1;
        break;
      end
    end

    ev = 32'd0;
    if (!err_hit && !we) begin
      for (int b = 0; b < nb; b++) ev[8*b +: 8] = mem_byte(addr + 32'(b));
      if (size == 0) ev = (sg && ev[7]) ? (ev | 32'hFFFF_FF00) : (ev & 32'h0000_00FF);
      if (size == 1) ev = (sg && ev[15]) ? (ev | 32'hFFFF_0000) : (ev & 32'h0000_FFFF);
    end
    tg = err_hit ? "R6" : "R5";
    chk(rsp_valid[m] == 1'b1, tg, {31'd0, rsp_valid[m]}, 32'd1);
    chk(bus_req_valid[m] == 1'b0, "R6 no further transfer", {31'd0, bus_req_valid[m]}, 32'd0);
    chk(rsp_err[m] == err_hit, tg, {31'd0, rsp_err[m]}, {31'd0, err_hit});
    chk(rsp_rdata[m] == ev, tg, rsp_rdata[m], ev);
    held_rd  = rsp_rdata[m];
    held_err = rsp_err[m];
    @(negedge clk);
    chk(rsp_valid[m] && rsp_rdata[m] == held_rd && rsp_err[m] == held_err, "R8 rsp hold",
        rsp_rdata[m], held_rd);
    rsp_ready[m] = 1'b1;
    @(negedge clk);
    rsp_ready[m] = 1'b0;
    chk(rsp_valid[m] == 1'b0 && req_ready[m] == 1'b1, "R7 idle again",
        {30'd0, rsp_valid[m], req_ready[m]}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    for (int m = 0; m < 2; m++) begin
      req_valid[m] = 1'b0; req_addr[m] = 32'd0; req_size[m] = 2'd0; req_write[m] = 1'b0;
      req_signed[m] = 1'b0; req_wdata[m] = 32'd0; rsp_ready[m] = 1'b0;
      bus_req_ready[m] = 1'b0; bus_rsp_valid[m] = 1'b0; bus_rsp_rdata[m] = 32'd0;
      bus_rsp_err[m] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      chk(req_ready[m] && !bus_req_valid[m] && !rsp_valid[m], "R7 reset",
          {29'd0, req_ready[m], bus_req_valid[m], rsp_valid[m]}, 32'd4);
    end
    for (int m = 0; m < 2; m++) begin
      run_op(m, 32'h100, 2, 1'b0, 1'b1, 32'd0, -1);
      run_op(m, 32'h101, 1, 1'b0, 1'b1, 32'd0, -1);
      run_op(m, 32'h103, 1, 1'b0, 1'b0, 32'd0, -1);
      run_op(m, 32'h105, 2, 1'b0, 1'b1, 32'd0, -1);
      run_op(m, 32'h10A, 2, 1'b1, 1'b0, 32'hA1B2_C3D4, -1);
      run_op(m, 32'h10F, 2, 1'b1, 1'b0, 32'h1122_3344, -1);
      run_op(m, 32'h112, 0, 1'b0, 1'b1, 32'd0, -1);
      run_op(m, 32'h117, 1, 1'b1, 1'b0, 32'h0000_BEEF, -1);
      run_op(m, 32'h11B, 2, 1'b0, 1'b1, 32'd0, 1);
      run_op(m, 32'h120, 2, 1'b0, 1'b0, 32'd0, 0);
      run_op(m, 32'h126, 1, 1'b0, 1'b1, 32'd0, -1);
      run_op(m, 32'h12D, 2, 1'b0, 1'b0, 32'd0, 2);
      run_op(m, 32'h133, 0, 1'b0, 1'b0, 32'd0, -1);
    end
    summary();
    $finish;
  end
endmodule